// File: doc/BRIEF.md
# Test Access Port with Core Wrapper Bridge

This block is a test access port (TAP) controller for the top of a chip. Besides the standard BYPASS register, it has two private instructions. Each one turns the TAP's data-register scan into control of a daisy chain of core test wrappers. The wrappers are chained serially. The first takes its serial input from TDI, and the last returns its serial output to the block, which forwards it to TDO.

With the wrapper-instruction opcode loaded, the Shift-DR and Update-DR states of the TAP drive the wrappers' instruction-path shift and update strobes, and the instruction-select line is high. With the wrapper-data opcode loaded, the same states drive the data-path strobes and instruction-select is low. Any other opcode leaves every wrapper strobe low and scans through a single bypass bit. The wrapper clock and reset are the TAP clock and reset passed straight through.

Top module: `jtag_wrap_bridge`

## Requirements
- R1: `wrapClk` equals `tck`, `wrapRstN` equals `trstN` and `wrapSi` equals `tdi` at all times, with no register in between.
- R2: The controller follows the standard 16-state TAP state diagram, advancing on the rising edge of `tck` under `tms`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and Test-Logic-Reset reloads the instruction register with BYPASS (4'hF).
- R3: The instruction register is 4 bits. Capture-IR loads 4'b0001 into its shift stage. Shift-IR shifts LSB first, with `tdi` entering at bit 3 and bit 0 going out on TDO. The new opcode takes effect from the rising edge that leaves Update-IR.
- R4: With opcode 4'h8 loaded, `wrapSelInstr` is high, `wrapShiftInstr` is high exactly while the TAP is in Shift-DR, and `wrapUpdateInstr` is high exactly while it is in Update-DR. Both data strobes stay low.
- R5: With opcode 4'h9 loaded, `wrapSelInstr` is low, `wrapShiftData` follows Shift-DR and `wrapUpdateData` follows Update-DR. Both instruction strobes stay low.
- R6: With any other opcode, `wrapSelInstr` and all four wrapper strobes are low. The data path is a 1-bit bypass register that loads 0 in Capture-DR and samples `tdi` on each rising edge in Shift-DR.
- R7: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is high for the half-cycle after the falling edge in Shift-IR or Shift-DR and low otherwise, and `tdo` is 0 whenever `tdoEn` is low.
- R8: Under either wrapper opcode, Shift-DR samples `wrapSoReturn` on the rising edge (it is cleared in Capture-DR), and the next falling edge launches that sample on `tdo`. The block therefore adds one bit to the chain length.
- R9: Each update strobe is high for exactly one `tck` cycle per pass through Update-DR.
- R10: While `trstN` is low, the controller is held in Test-Logic-Reset, the opcode is BYPASS, and `tdo` and `tdoEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| tdoEn | output | 1 | Output enable for `tdo` |
| wrapClk | output | 1 | Wrapper clock (pass-through of `tck`) |
| wrapRstN | output | 1 | Wrapper reset, active low (pass-through of `trstN`) |
| wrapSelInstr | output | 1 | High while the wrapper instruction path is selected |
| wrapShiftInstr | output | 1 | Wrapper instruction-path shift strobe |
| wrapUpdateInstr | output | 1 | Wrapper instruction-path update strobe |
| wrapShiftData | output | 1 | Wrapper data-path shift strobe |
| wrapUpdateData | output | 1 | Wrapper data-path update strobe |
| wrapSi | output | 1 | Serial input of the first wrapper |
| wrapSoReturn | input | 1 | Serial output of the last wrapper |

## Verification
The strobes and the select line are combinational from the controller state and the opcode. They are therefore due in the same `tck` cycle as the rising edge that entered the state, and a newly loaded opcode shows on them from the cycle after Update-IR. `tdo` and `tdoEn` follow half a cycle later, on the falling edge, and `tdo` under a wrapper opcode carries the return bit sampled on the rising edge before it. The bench drives inputs just after each falling edge and compares every output with a behavioural reference just before the next rising edge. At that point all results for the current cycle are due and none for the next has appeared.

// File: rtl/jtag_wrap_pkg.sv
package jtag_wrap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
  } tapStrobes_t;

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_wrap_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapStrobes_t strb
);

  tapState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strb.inReset = (state == ST_RESET);
    strb.capIr   = (state == ST_CAP_IR);
    strb.shIr    = (state == ST_SH_IR);
    strb.updIr   = (state == ST_UPD_IR);
    strb.capDr   = (state == ST_CAP_DR);
    strb.shDr    = (state == ST_SH_DR);
    strb.updDr   = (state == ST_UPD_DR);
  end

  // Checker counter: consecutive rising edges with tms high, saturating at 5
  logic [2:0] tmsHighRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                tmsHighRun <= '0;
    else if (!tms)             tmsHighRun <= '0;
    else if (tmsHighRun != 3'd5) tmsHighRun <= tmsHighRun + 3'd1;
  end

  // R2: five tms-high clocks always land in Test-Logic-Reset
  p_reset_after_five_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tmsHighRun == 3'd5) |-> (state == ST_RESET));

  // R9: Update-DR never lasts more than one cycle
  p_update_one_cycle_r9: assert property (@(posedge tck) disable iff (!trstN)
    strb.updDr |=> !strb.updDr);

  // R3: Capture-IR is always followed by Shift-IR or Exit1-IR
  p_capir_next_r3: assert property (@(posedge tck) disable iff (!trstN)
    strb.capIr |=> (state == ST_SH_IR || state == ST_EX1_IR));

endmodule

// File: rtl/jtag_wrap_datapath.sv
module jtag_wrap_datapath
  import jtag_wrap_pkg::*;
#(
  parameter logic [IR_W-1:0] OP_BYPASS   = '1,
  parameter logic [IR_W-1:0] OP_WRAP_INS = 4'h8,
  parameter logic [IR_W-1:0] OP_WRAP_DAT = 4'h9,
  parameter logic [IR_W-1:0] IR_CAPTURE  = 4'b0001
) (
  input  logic        tck,
  input  logic        trstN,
  input  logic        tdi,
  input  tapStrobes_t strb,
  input  logic        wrapSoReturn,
  output logic        tdo,
  output logic        tdoEn,
  output logic        wrapSelInstr,
  output logic        wrapShiftInstr,
  output logic        wrapUpdateInstr,
  output logic        wrapShiftData,
  output logic        wrapUpdateData
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  logic            bypassBit;
  logic            returnBit;
  logic            isWrapIns, isWrapDat, wrapPath;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          irShift <= '0;
    else if (strb.capIr) irShift <= IR_CAPTURE;
    else if (strb.shIr)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irActive <= OP_BYPASS;
    else if (strb.inReset) irActive <= OP_BYPASS;
    else if (strb.updIr)   irActive <= irShift;
  end

  assign isWrapIns = (irActive == OP_WRAP_INS);
  assign isWrapDat = (irActive == OP_WRAP_DAT);
  assign wrapPath  = isWrapIns | isWrapDat;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      returnBit <= 1'b0;
    end else if (strb.capDr) begin
      bypassBit <= 1'b0;
      returnBit <= 1'b0;
    end else if (strb.shDr) begin
      bypassBit <= tdi;
      returnBit <= wrapSoReturn;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shIr | strb.shDr;
      if (strb.shIr)      tdo <= irShift[0];
      else if (strb.shDr) tdo <= wrapPath ? returnBit : bypassBit;
      else                tdo <= 1'b0;
    end
  end

  assign wrapSelInstr    = isWrapIns;
  assign wrapShiftInstr  = isWrapIns & strb.shDr;
  assign wrapUpdateInstr = isWrapIns & strb.updDr;
  assign wrapShiftData   = isWrapDat & strb.shDr;
  assign wrapUpdateData  = isWrapDat & strb.updDr;

  // R4/R5: at most one wrapper strobe at a time
  p_one_strobe_r4: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({wrapShiftInstr, wrapUpdateInstr, wrapShiftData, wrapUpdateData}));

  // R4: instruction-path strobes only with select high
  p_ins_sel_high_r4: assert property (@(posedge tck) disable iff (!trstN)
    (wrapShiftInstr | wrapUpdateInstr) |-> wrapSelInstr);

  // R5: data-path strobes only with select low
  p_dat_sel_low_r5: assert property (@(posedge tck) disable iff (!trstN)
    (wrapShiftData | wrapUpdateData) |-> !wrapSelInstr);

  // R3: Capture-IR leaves the fixed pattern in the shift stage
  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trstN)
    strb.capIr |=> (irShift == IR_CAPTURE));

  // R2: Test-Logic-Reset restores BYPASS
  p_reset_bypass_r2: assert property (@(posedge tck) disable iff (!trstN)
    strb.inReset |=> (irActive == OP_BYPASS));

  // R6: opcode only changes on leaving Update-IR or Test-Logic-Reset
  p_ir_stable_r6: assert property (@(posedge tck) disable iff (!trstN)
    (!strb.updIr && !strb.inReset) |=> $stable(irActive));

endmodule

// File: rtl/jtag_wrap_bridge.sv
module jtag_wrap_bridge
  import jtag_wrap_pkg::*;
(
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trstN,
  output logic tdo,
  output logic tdoEn,
  output logic wrapClk,
  output logic wrapRstN,
  output logic wrapSelInstr,
  output logic wrapShiftInstr,
  output logic wrapUpdateInstr,
  output logic wrapShiftData,
  output logic wrapUpdateData,
  output logic wrapSi,
  input  logic wrapSoReturn
);

  tapStrobes_t strb;

  assign wrapClk  = tck;
  assign wrapRstN = trstN;
  assign wrapSi   = tdi;

  jtag_tap_ctrl u_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strb  (strb)
  );

  jtag_wrap_datapath u_dp (
    .tck             (tck),
    .trstN           (trstN),
    .tdi             (tdi),
    .strb            (strb),
    .wrapSoReturn    (wrapSoReturn),
    .tdo             (tdo),
    .tdoEn           (tdoEn),
    .wrapSelInstr    (wrapSelInstr),
    .wrapShiftInstr  (wrapShiftInstr),
    .wrapUpdateInstr (wrapUpdateInstr),
    .wrapShiftData   (wrapShiftData),
    .wrapUpdateData  (wrapUpdateData)
  );

endmodule

// File: tb/jtag_wrap_bridge_tb.sv
module jtag_wrap_bridge_tb;

  localparam int CLK_PERIOD = 20;
  localparam int HALF = CLK_PERIOD / 2;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, trstN = 1'b0, wso = 1'b0;
  logic tdo, tdoEn, wrapClk, wrapRstN, wSel, wShI, wUpI, wShD, wUpD, wrapSi;

  int checks = 0;
  int errors = 0;

  jtag_wrap_bridge u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .tdo(tdo), .tdoEn(tdoEn), .wrapClk(wrapClk), .wrapRstN(wrapRstN),
    .wrapSelInstr(wSel), .wrapShiftInstr(wShI), .wrapUpdateInstr(wUpI),
    .wrapShiftData(wShD), .wrapUpdateData(wUpD), .wrapSi(wrapSi),
    .wrapSoReturn(wso)
  );

  always #HALF tck = ~tck;

  // ---------------- behavioural reference ----------------
  string mState = "RESET";
  int    mIr = 15, mIrSh = 0;
  bit    mByp = 0, mRet = 0, mTdo = 0, mTdoEn = 0;

  function automatic string stepState(string s, bit m);
    case (s)
      "RESET":  return m ? "RESET" : "IDLE";
      "IDLE":   return m ? "SELDR" : "IDLE";
      "SELDR":  return m ? "SELIR" : "CAPDR";
      "CAPDR":  return m ? "EX1DR" : "SHDR";
      "SHDR":   return m ? "EX1DR" : "SHDR";
      "EX1DR":  return m ? "UPDDR" : "PAUDR";
      "PAUDR":  return m ? "EX2DR" : "PAUDR";
      "EX2DR":  return m ? "UPDDR" : "SHDR";
      "UPDDR":  return m ? "SELDR" : "IDLE";
      "SELIR":  return m ? "RESET" : "CAPIR";
      "CAPIR":  return m ? "EX1IR" : "SHIR";
      "SHIR":   return m ? "EX1IR" : "SHIR";
      "EX1IR":  return m ? "UPDIR" : "PAUIR";
      "PAUIR":  return m ? "EX2IR" : "PAUIR";
      "EX2IR":  return m ? "UPDIR" : "SHIR";
      default:  return m ? "SELDR" : "IDLE";
    endcase
  endfunction

  always @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      mState = "RESET"; mIr = 15; mIrSh = 0; mByp = 0; mRet = 0;
    end else begin
      if (mState == "CAPIR") mIrSh = 1;
      else if (mState == "SHIR") mIrSh = (mIrSh / 2) + (tdi ? 8 : 0);
      if (mState == "RESET") mIr = 15;
      else if (mState == "UPDIR") mIr = mIrSh;
      if (mState == "CAPDR") begin mByp = 0; mRet = 0; end
      else if (mState == "SHDR") begin mByp = tdi; mRet = wso; end
      mState = stepState(mState, tms);
    end
  end

  always @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      mTdo = 0; mTdoEn = 0;
    end else begin
      mTdoEn = (mState == "SHIR") || (mState == "SHDR");
      if (mState == "SHIR") mTdo = mIrSh[0];
      else if (mState == "SHDR") mTdo = (mIr == 8 || mIr == 9) ? mRet : mByp;
      else mTdo = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit inWi, inWd;
    inWi = (mIr == 8);
    inWd = (mIr == 9);
    chk("R1", "wrapClk",  wrapClk,  tck);
    chk("R1", "wrapRstN", wrapRstN, trstN);
    chk("R1", "wrapSi",   wrapSi,   tdi);
    chk("R4", "wrapSelInstr",    wSel, inWi);
    chk("R4", "wrapShiftInstr",  wShI, inWi && mState == "SHDR");
    chk("R9", "wrapUpdateInstr", wUpI, inWi && mState == "UPDDR");
    chk("R5", "wrapShiftData",   wShD, inWd && mState == "SHDR");
    chk("R9", "wrapUpdateData",  wUpD, inWd && mState == "UPDDR");
    chk("R7", "tdoEn", tdoEn, mTdoEn);
    chk((inWi || inWd) ? "R8" : "R6", "tdo", tdo, mTdo);
  endtask

  // compare just before every rising edge
  always @(negedge tck) begin
    #(HALF - 2);
    compareAll();
  end

  // ---------------- stimulus ----------------
  task automatic step(bit m, bit d = 0, bit r = 0);
    tms = m; tdi = d; wso = r;
    @(negedge tck); #2;
  endtask

  task automatic loadIr(int op);   // from Idle, back to Idle (R3)
    step(1); step(1); step(0); step(0);       // SelDR SelIR CapIR ShIR
    for (int i = 0; i < 4; i++) step(i == 3, op[i]);
    step(1); step(0);                          // UpdIR -> Idle
  endtask

  task automatic scanDr(int n, bit pauseMid);   // from Idle, back to Idle
    step(1); step(0); step(0);                 // SelDR CapDR ShDR
    for (int i = 0; i < n; i++) begin
      if (pauseMid && i == n / 2) begin
        step(1, $urandom_range(1), $urandom_range(1));  // Exit1
        step(0); step(0); step(1); step(0);            // Pause x2, Exit2, ShDR
      end
      step(i == n - 1, $urandom_range(1), $urandom_range(1));
    end
    step(1); step(0);                          // UpdDR -> Idle
  endtask

  initial begin
    // R10: held in reset
    @(negedge tck); #2;
    @(negedge tck); #2;
    trstN = 1'b1;
    step(0);                                   // Idle
    loadIr(8);  scanDr(7, 0);                  // R4
    loadIr(8);  scanDr(6, 1);
    loadIr(9);  scanDr(9, 0);                  // R5
    loadIr(9);  scanDr(5, 1);
    loadIr(3);  scanDr(6, 0);                  // R6 other opcode
    loadIr(15); scanDr(4, 1);
    loadIr(8);
    step(1); step(0); step(0); step(0, 1, 1);  // mid Shift-DR
    for (int i = 0; i < 5; i++) step(1);       // R2 escape to reset
    step(0); scanDr(4, 0);                     // bypass again
    loadIr(9);
    step(1); step(0); step(0, 1, 1);
    #3 trstN = 1'b0;                           // R10 async reset mid-scan
    step(1); step(0);
    trstN = 1'b1;
    step(0); scanDr(3, 0);
    for (int i = 0; i < 600; i++)              // random walk of the TAP
      step($urandom_range(3) == 0, $urandom_range(1), $urandom_range(1));
    for (int i = 0; i < 5; i++) step(1);
    step(0); loadIr(8); scanDr(8, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule